// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block holds the output state of eight general-purpose pins and the direction of each pin, and it exposes both on a small memory-mapped bus. The bus uses a word address, separate read and write strobes, and 32-bit data. The data register appears at every one of 256 consecutive word locations. The low eight bits of the word address within that window act as a per-pin access mask. A driver that owns some pins can therefore set, clear or read exactly those pins in one access. It needs no read-modify-write sequence and cannot disturb pins that other drivers own.

The block drives a value and an output enable for each pin. It also samples the pin inputs through a two-stage synchronizer. A data read returns the stored output value for pins set as outputs, and the synchronized pin level for pins set as inputs. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, and reads of the data window and of the direction word return zero while the pins are held low.
- R2: A write to word address 0x000–0x0FF updates data bit i with `bus_wdata[i]` only when address bit i is 1 and direction bit i is 1. The result appears on `pin_out` from the cycle after the write.
- R3: During a data write, any bit whose address mask bit is 0 keeps its previous value.
- R4: A data write leaves bits configured as inputs unchanged. If such a pin is later switched to output, it drives the value it held before that write.
- R5: On a data read, result bit i is 0 whenever address bit i is 0.
- R6: On a data read with mask bit i set, result bit i is the stored value if direction bit i is 1. If direction bit i is 0, it is the pin level seen through two synchronizer flops. A read issued in the same cycle as a pin change returns the old level, and a read issued three or more cycles later returns the new level.
- R7: Word address 0x100 holds the direction register. Writing it sets `pin_oe` to `bus_wdata[7:0]` from the next cycle (1 = output, 0 = input), and reading it returns that value.
- R8: `bus_rdata[31:8]` is always zero.
- R9: Writes to any word address other than 0x000–0x100 change neither `pin_out` nor `pin_oe`, and reads there return zero.
- R10: `bus_rdata` carries a result in the cycle after `bus_rd` is sampled high and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads, asynchronous |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The assertions assume that each bus strobe lasts exactly one cycle and that the address and write data are stable while a strobe is high. They also assume that the strobes stay low while reset is asserted. The bench drives every access from the falling clock edge as a single-cycle pulse, issues one access at a time, and holds reset with both strobes low. The pin inputs are treated as asynchronous. The bench changes them only on falling edges and waits out the synchronizer depth before it expects a new level.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    localparam int PIN_W     = 8;
    localparam int BUS_W     = 32;
    localparam int WADDR_W   = 10;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DATA = 2'd1,
        TGT_DIR  = 2'd2
    } target_e;

    typedef struct packed {
        target_e              tgt;
        logic [PIN_W-1:0]     mask;
    } access_t;

    function automatic logic [PIN_W-1:0] merge_bits(
        input logic [PIN_W-1:0] old_v,
        input logic [PIN_W-1:0] new_v,
        input logic [PIN_W-1:0] sel
    );
        return (old_v & ~sel) | (new_v & sel);
    endfunction

endpackage

// File: rtl/gpm_decode.sv
module gpm_decode
    import gpm_pkg::*;
#(
    parameter int AW = WADDR_W,
    parameter int PW = PIN_W
) (
    input  logic [AW-1:0] addr,
    output access_t       acc
);
    localparam int HI_W = AW - PW;
    localparam logic [HI_W-1:0] DIR_HI = HI_W'(1);

    logic [HI_W-1:0] hi;
    logic [PW-1:0]   lo;

    assign hi = addr[AW-1:PW];
    assign lo = addr[PW-1:0];

    always_comb begin
        acc.tgt  = TGT_NONE;
        acc.mask = '0;
        if (hi == '0) begin
            acc.tgt  = TGT_DATA;
            acc.mask = lo;
        end else if (hi == DIR_HI && lo == '0) begin
            acc.tgt  = TGT_DIR;
            acc.mask = '1;
        end
    end
endmodule

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0] chain [W];

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) chain[b] <= '0;
            else     chain[b] <= {chain[b][STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int PW = PIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  access_t       acc,
    input  logic [PW-1:0] wbits,
    output logic [PW-1:0] data_q,
    output logic [PW-1:0] dir_q
);
    logic [PW-1:0] data_we;
    logic          dir_we;

    assign data_we = (wr && acc.tgt == TGT_DATA) ? (acc.mask & dir_q) : '0;
    assign dir_we  = wr && acc.tgt == TGT_DIR;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            data_q <= merge_bits(data_q, wbits, data_we);
            if (dir_we) dir_q <= wbits;
        end
    end
endmodule

// File: rtl/gpm_rdata.sv
module gpm_rdata
    import gpm_pkg::*;
#(
    parameter int PW = PIN_W,
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  access_t       acc,
    input  logic [PW-1:0] data_q,
    input  logic [PW-1:0] dir_q,
    input  logic [PW-1:0] pins_s,
    output logic [DW-1:0] rdata
);
    logic [PW-1:0] live;
    logic [PW-1:0] sel_v;

    assign live = merge_bits(pins_s, data_q, dir_q);

    always_comb begin
        unique case (acc.tgt)
            TGT_DATA: sel_v = live & acc.mask;
            TGT_DIR:  sel_v = dir_q;
            default:  sel_v = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= DW'(sel_v);
        else         rdata <= '0;
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpm_pkg::*;
#(
    parameter int AW = WADDR_W,
    parameter int PW = PIN_W,
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe
);
    access_t       acc;
    logic [PW-1:0] data_q;
    logic [PW-1:0] dir_q;
    logic [PW-1:0] pins_s;
    logic          unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DW-1:PW];

    gpm_decode #(.AW(AW), .PW(PW)) u_decode (
        .addr (bus_addr),
        .acc  (acc)
    );

    gpm_regs #(.PW(PW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .acc    (acc),
        .wbits  (bus_wdata[PW-1:0]),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpm_sync #(.W(PW), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pins_s)
    );

    gpm_rdata #(.PW(PW), .DW(DW)) u_rdata (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .acc    (acc),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pins_s (pins_s),
        .rdata  (bus_rdata)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int AW = 10,
    parameter int PW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic [PW-1:0] pin_out,
    input logic [PW-1:0] pin_oe
);
    logic in_data;
    logic in_dir;

    assign in_data = bus_addr[AW-1:PW] == '0;
    assign in_dir  = bus_addr == AW'(1 << PW);

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DW-1:PW] == '0);  // R8

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> bus_rdata == '0);  // R10

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> ($stable(pin_out) && $stable(pin_oe)));  // R2

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_data) |=>
        ((pin_out ^ $past(pin_out)) & ~($past(bus_addr[PW-1:0]) & $past(pin_oe))) == '0);  // R3

    AST_UNDEF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_data && !in_dir) |=> ($stable(pin_out) && $stable(pin_oe)));  // R9

    AST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && in_data) |=> (bus_rdata[PW-1:0] & ~$past(bus_addr[PW-1:0])) == '0);  // R5
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.AW(AW), .PW(PW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        bus_read(10'h0FF, rv); check("R1 data read", rv, 32'h0);
        bus_read(10'h100, rv); check("R1 dir read", rv, 32'h0);
        check("R10 idle rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_direction;
        bus_write(10'h100, 32'hFFFF_FF0F);
        check("R7 pin_oe", 32'(pin_oe), 32'h0F);
        bus_read(10'h100, rv); check("R7 dir read", rv, 32'h0F);
    endtask

    task automatic t_masked_write;
        bus_write(10'h005, 32'hFFFF_FFFF);
        check("R2 masked set", 32'(pin_out), 32'h05);
        bus_write(10'h001, 32'h0);
        check("R3 others kept", 32'(pin_out), 32'h04);
        bus_write(10'h00B, 32'h0000_0003);
        check("R2 mixed write", 32'(pin_out), 32'h07);
    endtask

    task automatic t_input_ignore;
        bus_write(10'h0F0, 32'hFFFF_FFFF);
        check("R4 inputs unchanged", 32'(pin_out), 32'h07);
        bus_write(10'h100, 32'hFF);
        check("R4 old value driven", 32'(pin_out), 32'h07);
        bus_read(10'h0FF, rv); check("R6 all-output read", rv, 32'h07);
        bus_write(10'h100, 32'h0F);
    endtask

    task automatic t_read_mix;
        @(negedge clk); pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        bus_read(10'h0FF, rv); check("R6 mixed read", rv, 32'h0000_00A7);
        check("R8 upper zero", {8'h0, rv[31:8]}, 32'h0);
        bus_read(10'h030, rv); check("R5 mask clears", rv, 32'h20);
        bus_read(10'h000, rv); check("R5 empty mask", rv, 32'h0);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pin_in = 8'h50; bus_addr = 10'h0F0; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0; rv = bus_rdata;
        check("R6 sync old level", rv, 32'hA0);
        repeat (3) @(negedge clk);
        bus_read(10'h0F0, rv); check("R6 sync new level", rv, 32'h50);
    endtask

    task automatic t_undefined;
        bus_write(10'h101, 32'hFFFF_FFFF);
        bus_write(10'h200, 32'hFFFF_FFFF);
        bus_write(10'h3FF, 32'h0);
        check("R9 pin_out kept", 32'(pin_out), 32'h07);
        check("R9 pin_oe kept", 32'(pin_oe), 32'h0F);
        bus_read(10'h101, rv); check("R9 read zero", rv, 32'h0);
        bus_read(10'h3FF, rv); check("R9 read zero high", rv, 32'h0);
        @(negedge clk); check("R10 zero after read", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_input_ignore();
        t_read_mix();
        t_sync();
        t_undefined();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule